// File: doc/BRIEF.md
# Pulse Train Generator Counter

This block is a memory-mapped peripheral that produces a square wave on one output pin and stops by itself after a programmed number of level changes. A byte-wide write/read bus reaches six registers. Two bytes hold a 16-bit prescaler reload value, two bytes hold a 16-bit count, one byte holds the control bits (run, interrupt enable, pending, test), and one byte holds the pin's data level and direction.

The system clock is first halved by an internal two-phase divider. Each divided tick decrements the prescaler. When the prescaler passes zero, it reloads from the reload registers, the pin level inverts and the count decrements. When the count passes zero, the block stops itself, sets the pending flag and, if interrupts are enabled, raises an interrupt request. Setting the run bit always reloads the prescaler first, so the first half-period after any start or restart is full width. Clearing the run bit freezes both the count and the pin level.

A three-state machine holds the run state. PTG_STOP is idle. PTG_PH_A is the first divider phase. PTG_PH_B is the second phase, and it is the one that delivers a prescaler tick. The transitions are as follows:
- START goes from PTG_STOP to PTG_PH_A when software writes run=1.
- ADVANCE goes from PTG_PH_A to PTG_PH_B.
- TICK goes from PTG_PH_B back to PTG_PH_A.
- HALT goes from PTG_PH_A or PTG_PH_B to PTG_STOP when software writes run=0.
- EXPIRE goes from PTG_PH_B to PTG_STOP on a count underflow.

Top module: `ptg_counter`

## Requirements
- R1: Asynchronous reset (rst_n low) clears run, interrupt enable, pending, test, pin level and pin direction. The prescaler reload bytes (addresses 0 and 1) and the count bytes (addresses 2 and 3) keep their contents.
- R2: A write of 1 to run (address 4, bit 0) while stopped reloads the prescaler with reload value P. The first pin toggle then lands exactly 2*(P+1) clock edges after the edge that took the write, and every later toggle follows 2*(P+1) edges after the previous one.
- R3: Each prescaler underflow inverts pin_out and decrements the count. Starting from count N, exactly N+1 toggles occur before the block stops.
- R4: The underflow of the count clears run and sets pending (address 4, bit 2) on the same edge as the last toggle.
- R5: irq is high exactly when pending and interrupt enable (address 4, bit 1) are both 1.
- R6: A write of 0 to run freezes the count and pin_out until the next start.
- R7: Writing the port register (address 5, bit 0) sets pin_out directly. A level reached when the block stops stays in place until software rewrites it.
- R8: pin_oe follows the direction bit (address 5, bit 1), and that bit is 0 after reset.
- R9: In a control write, pending bit 0 clears the pending flag and pending bit 1 leaves it unchanged. A hardware set in the same cycle overrides a software clear.
- R10: A count byte written while running replaces that byte. The next decrement continues from the new value.
- R11: A count underflow on the same edge as a software stop still sets pending, and the block ends stopped.
- R12: Reads of address 4 return {test, pending, enable, run} in bits 3..0. Reads of address 5 return {direction, level} in bits 1..0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte for bus_addr (combinational) |
| pin_out | output | 1 | Pulse train level |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus holds at most one write per cycle and that a start write reaches the block only while it is stopped. A start written while the block is running is ignored by design, so the start-reload check is stated for starts from the stopped state only. The bench issues every register write at the falling edge, one at a time, and starts each run only after the previous one has stopped or been halted. It places the stop that races the final underflow on the exact edge computed from the reload and count values.

// File: rtl/ptg_pkg.sv
package ptg_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        PTG_STOP = 2'd0,
        PTG_PH_A = 2'd1,
        PTG_PH_B = 2'd2
    } ptg_state_e;

    // control byte fields
    localparam int CTL_RUN  = 0;
    localparam int CTL_IE   = 1;
    localparam int CTL_PEND = 2;
    localparam int CTL_TEST = 3;

    // port byte fields
    localparam int PORT_LVL = 0;
    localparam int PORT_DIR = 1;
endpackage

// File: rtl/ptg_fsm.sv
module ptg_fsm
    import ptg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_req,
    input  logic       stop_req,
    input  logic       cnt_uflow,
    output logic       running,
    output logic       tick
);
    ptg_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTG_STOP;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTG_STOP: if (start_req) state_d = PTG_PH_A;
            PTG_PH_A: state_d = stop_req ? PTG_STOP : PTG_PH_B;
            PTG_PH_B: state_d = (stop_req || cnt_uflow) ? PTG_STOP : PTG_PH_A;
            default:  state_d = PTG_STOP;
        endcase
    end

    always_comb begin
        running = (state_q != PTG_STOP);
        tick    = (state_q == PTG_PH_B);
    end

    // R4
    expire_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_uflow |=> (state_q == PTG_STOP));

    // R2
    start_enters_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PTG_STOP && start_req) |=> (state_q == PTG_PH_A));
endmodule

// File: rtl/ptg_prescaler.sv
module ptg_prescaler #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         tick,
    input  logic [W-1:0] reload,
    output logic         uflow
);
    logic [W-1:0] cnt_q;

    assign uflow = tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load || uflow)  cnt_q <= reload;
        else if (tick)           cnt_q <= cnt_q - W'(1);
    end

    // R2
    start_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == $past(reload)));

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/ptg_count.sv
module ptg_count #(
    parameter int W  = 16,
    parameter int NB = W / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] wr_be,
    input  logic [7:0]    wdata,
    input  logic          dec,
    output logic [W-1:0]  value,
    output logic          uflow
);
    logic [W-1:0] val_q, val_d;

    assign value = val_q;
    assign uflow = dec && (val_q == '0);

    always_comb begin
        val_d = val_q;
        if (|wr_be) begin
            for (int i = 0; i < NB; i++) begin
                if (wr_be[i]) val_d[8*i +: 8] = wdata;
            end
        end else if (dec) begin
            val_d = val_q - W'(1);
        end
    end

    always_ff @(posedge clk) begin
        val_q <= val_d;
    end

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !(|wr_be)) |=> (val_q == $past(val_q) - W'(1)));

    // R6
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dec && !(|wr_be)) |=> $stable(val_q));
endmodule

// File: rtl/ptg_counter.sv
module ptg_counter
    import ptg_pkg::*;
#(
    parameter int PRESC_W = 16,
    parameter int CNT_W   = 16,
    parameter int ADDR_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);
    localparam int PRE_NB   = PRESC_W / BYTE_W;
    localparam int CNT_NB   = CNT_W / BYTE_W;
    localparam int CNT_BASE = PRE_NB;
    localparam int CTL_IDX  = PRE_NB + CNT_NB;
    localparam int PORT_IDX = CTL_IDX + 1;
    localparam logic [ADDR_W-1:0] CTL_A  = ADDR_W'(CTL_IDX);
    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_IDX);

    logic [PRESC_W-1:0] reload_q;
    logic [CNT_NB-1:0]  cnt_be;
    logic [CNT_W-1:0]   cnt_val;
    logic ctl_wr, port_wr, start_req, stop_req;
    logic running, tick, presc_uflow, cnt_uflow;
    logic ie_q, pend_q, test_q, lvl_q, dir_q;

    assign ctl_wr    = bus_we && (bus_addr == CTL_A);
    assign port_wr   = bus_we && (bus_addr == PORT_A);
    assign start_req = ctl_wr && bus_wdata[CTL_RUN] && !running;
    assign stop_req  = ctl_wr && !bus_wdata[CTL_RUN];

    // reload bytes survive reset
    for (genvar g = 0; g < PRE_NB; g++) begin : g_reload
        always_ff @(posedge clk) begin
            if (bus_we && bus_addr == ADDR_W'(g))
                reload_q[8*g +: 8] <= bus_wdata;
        end
    end

    for (genvar g = 0; g < CNT_NB; g++) begin : g_cnt_be
        assign cnt_be[g] = bus_we && (bus_addr == ADDR_W'(CNT_BASE + g));
    end

    ptg_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .stop_req  (stop_req),
        .cnt_uflow (cnt_uflow),
        .running   (running),
        .tick      (tick)
    );

    ptg_prescaler #(.W(PRESC_W)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (start_req),
        .tick   (tick),
        .reload (reload_q),
        .uflow  (presc_uflow)
    );

    ptg_count #(.W(CNT_W), .NB(CNT_NB)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_be (cnt_be),
        .wdata (bus_wdata),
        .dec   (presc_uflow),
        .value (cnt_val),
        .uflow (cnt_uflow)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie_q   <= 1'b0;
            test_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (ctl_wr) begin
                ie_q   <= bus_wdata[CTL_IE];
                test_q <= bus_wdata[CTL_TEST];
            end
            if (cnt_uflow)
                pend_q <= 1'b1;
            else if (ctl_wr && !bus_wdata[CTL_PEND])
                pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            dir_q <= 1'b0;
        end else if (port_wr) begin
            lvl_q <= bus_wdata[PORT_LVL];
            dir_q <= bus_wdata[PORT_DIR];
        end else if (presc_uflow) begin
            lvl_q <= ~lvl_q;
        end
    end

    assign pin_out = lvl_q;
    assign pin_oe  = dir_q;
    assign irq     = pend_q && ie_q;

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < PRE_NB; i++)
            if (bus_addr == ADDR_W'(i)) bus_rdata = reload_q[8*i +: 8];
        for (int i = 0; i < CNT_NB; i++)
            if (bus_addr == ADDR_W'(CNT_BASE + i)) bus_rdata = cnt_val[8*i +: 8];
        if (bus_addr == CTL_A)
            bus_rdata = {4'b0, test_q, pend_q, ie_q, running};
        if (bus_addr == PORT_A)
            bus_rdata = {6'b0, dir_q, lvl_q};
    end

    // R4
    expire_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_uflow |=> pend_q);

    // R11
    race_stop_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_uflow && stop_req) |=> (pend_q && !running));

    // R3
    toggle_on_uflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (presc_uflow && !port_wr) |=> (lvl_q != $past(lvl_q)));

    // R6
    frozen_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !port_wr) |=> $stable(lvl_q));
endmodule

// File: tb/ptg_counter_tb.sv
module ptg_counter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] A_PLO = 3'd0, A_PHI = 3'd1, A_CLO = 3'd2,
                           A_CHI = 3'd3, A_CTL = 3'd4, A_PORT = 3'd5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_we = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_out, pin_oe, irq;

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptg_counter dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic setup(input int p, input int n, input logic lvl);
        bus_wr(A_PLO, 8'(p)); bus_wr(A_PHI, 8'(p >> 8));
        bus_wr(A_CLO, 8'(n)); bus_wr(A_CHI, 8'(n >> 8));
        bus_wr(A_PORT, {6'b0, 1'b1, lvl});
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        @(negedge clk);
        bus_rd(A_CTL, d);  check("R1 ctrl after reset", d, 0);
        bus_rd(A_PORT, d); check("R1 port after reset", d, 0);
        check("R8 pin_oe after reset", pin_oe, 0);
        check("R5 irq after reset", irq, 0);
    endtask

    // full train: waveform, auto-stop, pending, irq
    task automatic t_train(input int p, input int n, input logic lvl);
        logic [7:0] d;
        int hp = 2 * (p + 1);
        int bad_k = -1, bad_a = 0, bad_e = 0;
        setup(p, n, lvl);
        check("R8 pin_oe with direction set", pin_oe, 1);
        check("R7 level written", pin_out, lvl);
        bus_wr(A_CTL, 8'h03);
        for (int k = 1; k <= hp * (n + 1) + 6; k++) begin
            int tg;
            @(negedge clk);
            tg = k / hp;
            if (tg > n + 1) tg = n + 1;
            if (bad_k < 0 && pin_out != (lvl ^ tg[0])) begin
                bad_k = k; bad_a = pin_out; bad_e = lvl ^ tg[0];
            end
        end
        if (bad_k >= 0) $display("  waveform diverges at edge %0d", bad_k);
        check("R2 R3 pulse waveform", bad_a, bad_e);
        bus_rd(A_CTL, d);
        check("R4 R12 ctrl after expiry", d, 8'h06);
        check("R5 irq with pend and enable", irq, 1);
        bus_wr(A_CTL, 8'h04);
        check("R5 irq off with enable clear", irq, 0);
        bus_rd(A_CTL, d);
        check("R9 pend bit 1 keeps flag", d, 8'h04);
        bus_wr(A_CTL, 8'h02);
        bus_rd(A_CTL, d);
        check("R9 pend cleared by write 0", d, 8'h02);
        check("R9 irq after clear", irq, 0);
    endtask

    // stop freezes, level kept, restart full width
    task automatic t_stop_restart();
        logic [7:0] d;
        int bad = 0;
        setup(1, 10, 1'b1);
        bus_wr(A_CTL, 8'h01);
        repeat (20) @(negedge clk);
        bus_wr(A_CTL, 8'h00);
        check("R6 level at stop", pin_out, 0);
        bus_rd(A_CLO, d);
        check("R6 count at stop", d, 5);
        repeat (30) @(negedge clk);
        check("R7 low level held after stop", pin_out, 0);
        bus_rd(A_CLO, d);
        check("R6 count frozen", d, 5);
        bus_rd(A_CTL, d);
        check("R6 run clear", d[0], 0);
        bus_wr(A_PORT, 8'h03);
        check("R7 rewrite level", pin_out, 1);
        bus_wr(A_CTL, 8'h01);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (pin_out != ((k < 4) ? 1 : 0)) bad++;
        end
        check("R2 full first pulse after restart", bad, 0);
        bus_wr(A_CTL, 8'h00);
    endtask

    // rewriting the count while running
    task automatic t_live_rewrite();
        int tg = 0, stop_k = -1;
        logic prev;
        setup(3, 100, 1'b0);
        bus_wr(A_CTL, 8'h03);
        bus_wr(A_CHI, 8'h00);
        bus_wr(A_CLO, 8'h02);
        prev = pin_out;
        for (int k = 5; k <= 200; k++) begin
            @(negedge clk);
            if (pin_out != prev) tg++;
            prev = pin_out;
            if (stop_k < 0 && irq) stop_k = k;
        end
        check("R10 toggles after live rewrite", tg, 3);
        check("R10 expiry edge", stop_k, 24);
        bus_wr(A_CTL, 8'h02);
    endtask

    // stop racing the final underflow
    task automatic t_race_stop();
        logic [7:0] d;
        setup(0, 2, 1'b0);
        bus_wr(A_CTL, 8'h03);
        repeat (4) @(negedge clk);
        bus_wr(A_CTL, 8'h02);
        bus_rd(A_CTL, d);
        check("R11 pend set despite stop", d, 8'h06);
        check("R11 irq raised", irq, 1);
        check("R3 level after three toggles", pin_out, 1);
        bus_wr(A_CTL, 8'h02);
        check("R9 irq cleared", irq, 0);
    endtask

    task automatic t_reset_midrun();
        logic [7:0] d;
        setup(8'h5A, 50, 1'b0);
        bus_wr(A_CTL, 8'h0B);
        repeat (7) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_rd(A_CTL, d);  check("R1 ctrl cleared midrun", d, 0);
        bus_rd(A_PORT, d); check("R1 port cleared", d, 0);
        check("R8 pin_oe cleared", pin_oe, 0);
        bus_rd(A_PLO, d);  check("R1 reload kept", d, 8'h5A);
        bus_rd(A_CLO, d);  check("R1 count kept", d, 50);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_train(0, 0, 1'b0);
        t_train(2, 5, 1'b1);
        t_train(4, 3, 1'b0);
        t_stop_restart();
        t_live_rewrite();
        t_race_stop();
        t_reset_midrun();
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end
endmodule